// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. A 32-bit trace word stream enters over a valid/ready handshake and is stored in an on-chip circular RAM at the write pointer. The pointer wraps modulo the RAM depth, and a sticky flag records that a wrap has happened. A small register port lets software run capture and read the buffer out. Software can enable and disable capture, set a post-trigger word count, and control frame formatting and flushing. It can read the RAM one word at a time through a data register that advances the read pointer on each read. It can also write RAM words through a data register that advances the write pointer on each write.

Capture ends in one of three ways: software clears the enable, a trigger arrives and the programmed number of further words has been stored, or a manual flush completes with stop-on-flush selected. When frame formatting is on, every stop or flush first writes zero padding words until the write pointer is a multiple of four. The formatter stopped flag rises only after that padding. The stream is back-pressured: `in_ready` is high only while capture runs, no flush is pending, and no register write is in progress in the same cycle. A word is taken only in a cycle where `in_valid` and `in_ready` are both high. The source must hold the word until then.

Top module: `trace_ring_sink`

## Requirements
- R1: Register select codes: 0 depth (read-only, value DEPTH with bit 31 zero), 1 status (bit 0 wrapped), 2 read data, 3 read pointer, 4 write pointer, 5 post-trigger count, 6 capture control (bit 0 enable), 7 write data, 8 formatter status (bit 0 stopped), 9 formatter control. After reset: both pointers 0, wrapped 0, stopped 1, `in_ready` 0.
- R2: While capture runs, each accepted stream word is stored at the write pointer, and the write pointer then advances by one.
- R3: A read of code 2 returns the RAM word at the read pointer on `reg_rdata` in the next cycle, and the read pointer advances by one. Register reads appear one cycle after `reg_rd`.
- R4: A write to code 7 stores the data at the write pointer and advances it. Writes to codes 3 and 4 load the read and write pointers directly.
- R5: Both pointers wrap from DEPTH-1 to 0. The wrapped flag is set when the write pointer wraps, stays set across later writes, and is cleared only by a write to code 4.
- R6: With stop-on-trigger set (formatter control bit 3), a trigger stops capture after exactly N accepted words, where N is the post-trigger count. A word accepted in the trigger cycle counts toward N.
- R7: With N = 0, a trigger stops capture from the next cycle. Only the word accepted in the trigger cycle itself is kept.
- R8: A trigger has no effect when stop-on-trigger is clear. A second trigger after the first has no effect: the count is not reloaded.
- R9: With frame formatting on (formatter control bit 0), a stop or flush writes zero words until the write pointer is a multiple of 4. With formatting off, no padding is written.
- R10: Setting formatter control bit 1 starts a flush. The bit reads 1 until the flush finishes, then clears itself. Capture resumes afterwards unless stop-on-flush (bit 2) is set, in which case it stops.
- R11: Clearing capture enable stops capture after alignment, and formatter status bit 0 then reads 1. Writing 1 to the enable restarts capture and re-arms the trigger.
- R12: In any cycle with a register write, `in_ready` is low and padding pauses. At most one source writes the RAM in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Trace word offered |
| in_ready | output | 1 | Trace word can be taken this cycle |
| in_data | input | DW | Trace word |
| trig_in | input | 1 | Single-cycle trigger event |
| reg_sel | input | 4 | Register select code |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |

## Verification
Two functions can fall in the same cycle: a trigger can arrive together with an accepted stream word, and a register write can coincide with an offered word. The bench fires the trigger in the same cycle as an offered word. It then checks that the total number of accepted words is the pre-trigger count plus N, with the trigger-cycle word included, and it checks the last stored word by reading it back. It also raises a register write while a word is offered. There it checks that `in_ready` is low in that cycle, that the word is taken one cycle later, and that the write pointer shows exactly one store.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [3:0] {
    SEL_DEPTH = 4'd0,
    SEL_STAT  = 4'd1,
    SEL_RDATA = 4'd2,
    SEL_RPTR  = 4'd3,
    SEL_WPTR  = 4'd4,
    SEL_POST  = 4'd5,
    SEL_CAP   = 4'd6,
    SEL_WDATA = 4'd7,
    SEL_FSTAT = 4'd8,
    SEL_FCTL  = 4'd9
  } reg_sel_e;

  localparam int FC_FRAME   = 0;
  localparam int FC_FLUSH   = 1;
  localparam int FC_STOPFL  = 2;
  localparam int FC_STOPTRG = 3;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_RUN,
    ST_ALIGN,
    ST_PAD
  } cap_state_e;
endpackage

// File: rtl/trs_ram.sv
module trs_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/trs_ptrs.sv
module trs_ptrs #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_w,
  input  logic          load_w,
  input  logic          adv_r,
  input  logic          load_r,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          wrapped
);
  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      wrapped <= 1'b0;
    end else begin
      if (load_w) begin
        wptr    <= load_val;
        wrapped <= 1'b0;
      end else if (adv_w) begin
        wptr <= step(wptr);
        if (wptr == LAST) wrapped <= 1'b1;
      end
      if (load_r)     rptr <= load_val;
      else if (adv_r) rptr <= step(rptr);
    end
  end

  assert_rd_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_r && !load_r && rptr != LAST) |=> (rptr == $past(rptr) + AW'(1)));
  assert_wrap_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !load_w) |=> wrapped);
  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_w && !load_w && wptr == LAST) |=> (wptr == '0 && wrapped));
endmodule

// File: rtl/trs_ctrl.sv
module trs_ctrl
  import trs_pkg::*;
#(
  parameter int CW          = 16,
  parameter int FRAME_WORDS = 4,
  localparam int FB         = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_wr,
  input  logic          cap_bit,
  input  logic          fctl_wr,
  input  logic [3:0]    fctl_bits,
  input  logic [CW-1:0] post_cnt,
  input  logic          trig_in,
  input  logic          in_valid,
  input  logic          reg_wr,
  input  logic [FB-1:0] wptr_lo,
  output logic          in_ready,
  output logic          pad_we,
  output logic          cap_en,
  output logic [3:0]    fctl_rd,
  output logic          stopped
);
  cap_state_e    state;
  logic          frame_en, stop_fl, stop_trg, flush_busy, then_stop;
  logic          trig_seen;
  logic [CW-1:0] left;

  logic          running, in_acc, trig_now, armed, trig_done, last_pad, misaligned;
  logic [CW-1:0] base, nxt;

  always_comb begin
    running    = (state == ST_RUN);
    in_ready   = running && cap_en && !flush_busy && !reg_wr;
    in_acc     = in_ready && in_valid;
    trig_now   = running && trig_in && stop_trg && !trig_seen;
    armed      = trig_now || (running && trig_seen);
    base       = trig_now ? post_cnt : left;
    nxt        = (in_acc && base != '0) ? base - CW'(1) : base;
    trig_done  = armed && (nxt == '0);
    pad_we     = (state == ST_PAD) && !reg_wr;
    last_pad   = pad_we && (wptr_lo == FB'(FRAME_WORDS - 1));
    misaligned = (wptr_lo != '0);
  end

  assign stopped = (state == ST_OFF);
  assign fctl_rd = {stop_trg, stop_fl, flush_busy, frame_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_OFF;
      cap_en     <= 1'b0;
      frame_en   <= 1'b0;
      stop_fl    <= 1'b0;
      stop_trg   <= 1'b0;
      flush_busy <= 1'b0;
      then_stop  <= 1'b0;
      trig_seen  <= 1'b0;
      left       <= '0;
    end else begin
      unique case (state)
        ST_OFF: begin
          flush_busy <= 1'b0;
          if (cap_wr && cap_bit) begin
            state     <= ST_RUN;
            trig_seen <= 1'b0;
            left      <= '0;
          end
        end
        ST_RUN: begin
          if (armed)    left      <= nxt;
          if (trig_now) trig_seen <= 1'b1;
          if (!cap_en || trig_done || flush_busy) begin
            state     <= ST_ALIGN;
            then_stop <= !cap_en || trig_done || stop_fl;
          end
        end
        ST_ALIGN: begin
          if (frame_en && misaligned) begin
            state <= ST_PAD;
          end else begin
            flush_busy <= 1'b0;
            state      <= (then_stop || !cap_en) ? ST_OFF : ST_RUN;
          end
        end
        ST_PAD: begin
          if (last_pad) begin
            flush_busy <= 1'b0;
            state      <= (then_stop || !cap_en) ? ST_OFF : ST_RUN;
          end
        end
        default: state <= ST_OFF;
      endcase
      if (cap_wr) cap_en <= cap_bit;
      if (fctl_wr) begin
        frame_en <= fctl_bits[FC_FRAME];
        stop_fl  <= fctl_bits[FC_STOPFL];
        stop_trg <= fctl_bits[FC_STOPTRG];
        if (fctl_bits[FC_FLUSH]) flush_busy <= 1'b1;
      end
    end
  end

  assert_trig_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_done |=> !in_ready);
  assert_flush_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && flush_busy && !fctl_wr) |=> !flush_busy);
  assert_stop_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stopped) && frame_en && !$past(reg_wr)) |-> (wptr_lo == '0));
  assert_pad_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (!in_ready && !pad_we));
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink
  import trs_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int DW          = 32,
  parameter int CW          = 16,
  parameter int FRAME_WORDS = 4,
  localparam int AW         = $clog2(DEPTH),
  localparam int FB         = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          trig_in,
  input  logic [3:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata
);
  logic [AW-1:0] wptr, rptr;
  logic          wrapped, pad_we, cap_en, stopped;
  logic [3:0]    fctl_rd;
  logic [CW-1:0] post_cnt;
  logic [DW-1:0] ram_q, mem_wdata;
  logic          sw_we, in_we, mem_we;
  logic          wload, rload, rd_adv, cap_wr, fctl_wr, post_wr;

  always_comb begin
    sw_we     = reg_wr && (reg_sel == SEL_WDATA);
    wload     = reg_wr && (reg_sel == SEL_WPTR);
    rload     = reg_wr && (reg_sel == SEL_RPTR);
    cap_wr    = reg_wr && (reg_sel == SEL_CAP);
    fctl_wr   = reg_wr && (reg_sel == SEL_FCTL);
    post_wr   = reg_wr && (reg_sel == SEL_POST);
    rd_adv    = reg_rd && (reg_sel == SEL_RDATA);
    in_we     = in_valid && in_ready;
    mem_we    = sw_we || in_we || pad_we;
    mem_wdata = sw_we ? reg_wdata[DW-1:0] : (in_we ? in_data : '0);
  end

  trs_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk(clk), .we(mem_we), .waddr(wptr), .wdata(mem_wdata),
    .raddr(rptr), .rdata(ram_q)
  );

  trs_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .adv_w(mem_we), .load_w(wload),
    .adv_r(rd_adv), .load_r(rload), .load_val(reg_wdata[AW-1:0]),
    .wptr(wptr), .rptr(rptr), .wrapped(wrapped)
  );

  trs_ctrl #(.CW(CW), .FRAME_WORDS(FRAME_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cap_wr(cap_wr), .cap_bit(reg_wdata[0]),
    .fctl_wr(fctl_wr), .fctl_bits(reg_wdata[3:0]), .post_cnt(post_cnt),
    .trig_in(trig_in), .in_valid(in_valid), .reg_wr(reg_wr),
    .wptr_lo(wptr[FB-1:0]), .in_ready(in_ready), .pad_we(pad_we),
    .cap_en(cap_en), .fctl_rd(fctl_rd), .stopped(stopped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) post_cnt <= '0;
    else if (post_wr) post_cnt <= reg_wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_sel)
        SEL_DEPTH: reg_rdata <= 32'(DEPTH) & 32'h7fff_ffff;
        SEL_STAT:  reg_rdata <= {31'b0, wrapped};
        SEL_RDATA: reg_rdata <= 32'(ram_q);
        SEL_RPTR:  reg_rdata <= 32'(rptr);
        SEL_WPTR:  reg_rdata <= 32'(wptr);
        SEL_POST:  reg_rdata <= 32'(post_cnt);
        SEL_CAP:   reg_rdata <= {31'b0, cap_en};
        SEL_FSTAT: reg_rdata <= {31'b0, stopped};
        SEL_FCTL:  reg_rdata <= {28'b0, fctl_rd};
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assert_one_writer_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_we, in_we, pad_we}));
  assert_word_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_we |=> (wptr != $past(wptr)));
endmodule

// File: tb/trace_ring_sink_bench.sv
module trace_ring_sink_bench;
  localparam int DEPTH = 16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, trig_in = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [3:0]  reg_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trace_ring_sink #(.DEPTH(DEPTH)) u_trace_ring_sink (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .trig_in(trig_in), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stream(input int n, input logic [31:0] base, input int ta, input int tb, output int acc);
    acc = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = base + 32'(k);
      trig_in = (k == ta) || (k == tb);
      #1;
      if (in_ready) acc++;
    end
    @(negedge clk);
    in_valid = 1'b0; trig_in = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 in_ready after reset", 32'(in_ready), 32'd0);
    rd(4'd0, v); check("R1 depth", v, 32'(DEPTH));
    rd(4'd1, v); check("R1 wrapped", v, 32'd0);
    rd(4'd8, v); check("R1 stopped", v, 32'd1);
    rd(4'd3, v); check("R1 rptr", v, 32'd0);
    rd(4'd4, v); check("R1 wptr", v, 32'd0);
  endtask

  task automatic t_capture;
    logic [31:0] v; int acc;
    wr(4'd6, 32'd1);
    stream(5, 32'h100, -1, -1, acc);
    check("R2 accepted", 32'(acc), 32'd5);
    rd(4'd8, v); check("R11 running not stopped", v, 32'd0);
    wr(4'd6, 32'd0); idle(4);
    rd(4'd8, v); check("R11 stopped after disable", v, 32'd1);
    rd(4'd4, v); check("R9 no padding when off", v, 32'd5);
    wr(4'd3, 32'd0);
    for (int i = 0; i < 5; i++) begin
      rd(4'd2, v); check("R3 readout", v, 32'h100 + 32'(i));
    end
    rd(4'd3, v); check("R3 rptr advanced", v, 32'd5);
  endtask

  task automatic t_padding;
    logic [31:0] v; int acc;
    wr(4'd4, 32'd0); wr(4'd9, 32'd1); wr(4'd6, 32'd1);
    stream(6, 32'h200, -1, -1, acc);
    wr(4'd6, 32'd0); idle(6);
    rd(4'd4, v); check("R9 wptr aligned", v, 32'd8);
    wr(4'd3, 32'd5);
    rd(4'd2, v); check("R9 last data kept", v, 32'h205);
    rd(4'd2, v); check("R9 pad word 6", v, 32'd0);
    rd(4'd2, v); check("R9 pad word 7", v, 32'd0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(4'd9, 32'd0); wr(4'd4, 32'd0);
    for (int i = 0; i < DEPTH; i++) wr(4'd7, 32'h300 + 32'(i));
    rd(4'd1, v); check("R5 wrapped set", v, 32'd1);
    rd(4'd4, v); check("R5 wptr wrapped to 0", v, 32'd0);
    wr(4'd7, 32'h400);
    rd(4'd1, v); check("R5 wrapped sticky", v, 32'd1);
    wr(4'd3, 32'(DEPTH - 1));
    rd(4'd2, v); check("R4 word at end", v, 32'h300 + 32'(DEPTH - 1));
    rd(4'd2, v); check("R4 overwritten word 0", v, 32'h400);
    rd(4'd3, v); check("R5 rptr wrapped", v, 32'd1);
    wr(4'd4, 32'd3);
    rd(4'd1, v); check("R5 wrapped cleared by wptr write", v, 32'd0);
    rd(4'd4, v); check("R4 wptr load", v, 32'd3);
  endtask

  task automatic t_trigger;
    logic [31:0] v; int acc;
    wr(4'd4, 32'd0); wr(4'd5, 32'd3); wr(4'd9, 32'd8); wr(4'd6, 32'd1);
    stream(10, 32'h500, 2, -1, acc);
    check("R6 words up to trigger plus N", 32'(acc), 32'd5);
    idle(3);
    rd(4'd8, v); check("R6 stopped", v, 32'd1);
    rd(4'd4, v); check("R6 wptr", v, 32'd5);
    wr(4'd3, 32'd4);
    rd(4'd2, v); check("R6 last word", v, 32'h504);
    wr(4'd4, 32'd0); wr(4'd5, 32'd4); wr(4'd6, 32'd1);
    stream(10, 32'h600, 0, 2, acc);
    check("R8 second trigger ignored", 32'(acc), 32'd4);
    idle(3);
    wr(4'd9, 32'd0); wr(4'd4, 32'd0); wr(4'd6, 32'd1);
    stream(8, 32'h700, 1, -1, acc);
    check("R8 trigger ignored when disabled", 32'(acc), 32'd8);
    wr(4'd6, 32'd0); idle(3);
    wr(4'd4, 32'd0); wr(4'd5, 32'd0); wr(4'd9, 32'd8); wr(4'd6, 32'd1);
    stream(6, 32'h800, 1, -1, acc);
    check("R7 zero count keeps trigger word", 32'(acc), 32'd2);
    wr(4'd3, 32'd1);
    rd(4'd2, v); check("R7 trigger word stored", v, 32'h801);
  endtask

  task automatic t_flush;
    logic [31:0] v; int acc;
    wr(4'd4, 32'd0); wr(4'd9, 32'd1); wr(4'd6, 32'd1);
    stream(3, 32'h900, -1, -1, acc);
    wr(4'd9, 32'd3);
    rd(4'd9, v); check("R10 flush bit busy", v, 32'd3);
    idle(5);
    rd(4'd9, v); check("R10 flush bit self-clears", v, 32'd1);
    rd(4'd4, v); check("R10 flush padded", v, 32'd4);
    #1; check("R10 capture resumes", 32'(in_ready), 32'd1);
    stream(1, 32'h9a0, -1, -1, acc);
    check("R10 word after flush", 32'(acc), 32'd1);
    wr(4'd9, 32'd7); idle(6);
    rd(4'd8, v); check("R10 stop on flush", v, 32'd1);
    rd(4'd4, v); check("R10 wptr after stop flush", v, 32'd8);
    rd(4'd9, v); check("R10 control after flush", v, 32'd5);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(4'd9, 32'd0); wr(4'd4, 32'd0); wr(4'd6, 32'd1);
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'hA00;
    reg_sel = 4'd5; reg_wdata = 32'd7; reg_wr = 1'b1;
    #1; check("R12 ready low during reg write", 32'(in_ready), 32'd0);
    @(negedge clk);
    reg_wr = 1'b0;
    #1; check("R12 ready back", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    rd(4'd4, v); check("R12 single store", v, 32'd1);
    rd(4'd5, v); check("R12 reg write applied", v, 32'd7);
    wr(4'd6, 32'd0); idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_capture();
    t_padding();
    t_wrap();
    t_trigger();
    t_flush();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule